// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Engine

This block sits between a set of interrupt input pins and the processor-side interrupt controllers. Each pin has a redirection entry that holds a vector, a destination, a destination mode, a delivery mode, a polarity, a trigger mode and a mask. The block tracks one request bit and one remote-IRR bit per pin. It decides when a change on a pin becomes a delivery message, and it reports requests that are absorbed into an earlier one as coalesced.

Pin level changes arrive as single-cycle update strobes that carry a pin number and a level. Entries are written through a plain whole-entry write port. End-of-interrupt notices come in as strobes that carry a vector and a level/edge flag. All matching entries are resolved in the cycle the notice arrives, so a notice can be accepted every cycle.

Messages leave on a valid/ready stream. A message stays on the outputs, unchanged, until it is taken with valid and ready both high. While the stream is stalled, services still being decided are held as one pending bit per pin. When the output register is free, the lowest-numbered pending pin is loaded. Repeated services of a pin that is already pending merge into one message. Within one cycle the three inputs are applied in a fixed order: the entry write first, then the level update, then the end-of-interrupt notice.

Top module: `pde_top`

## Requirements
- R1: The effective level of a pin is its update level XOR the entry's polarity bit (1 = active low). An effective-low update clears the pin's request bit and produces no message and no coalesced pulse.
- R2: With trigger bit 0 (edge), an effective-high update services the pin only if its request bit was 0. If the request bit was already 1, the block emits a coalesced pulse tagged with the pin.
- R3: With trigger bit 1 (level), an effective-high update services the pin only if its remote IRR is clear. A level delivery sets the remote IRR, and a blocked update gives a coalesced pulse.
- R4: Servicing a pin whose mask bit is 1 produces no message, does not set the remote IRR and gives no coalesced pulse.
- R5: An end-of-interrupt notice with the level flag set affects every level-mode entry whose vector matches. It clears that entry's remote IRR and services the pin again if the entry is unmasked and its request bit is still set. A notice with the level flag clear has no effect.
- R6: Any write to an entry clears its remote IRR. If the new entry is level mode and the pin's request bit is set, the pin is serviced at once.
- R7: A message for pin 0 always carries destination mode 0 (physical) and the boot-processor ID input as its destination, whatever the entry holds.
- R8: A message carries the entry's destination, vector, destination mode (1 = logical), trigger bit and 3-bit delivery mode, together with its pin number, and its level output is 1.
- R9: A message stays stable while valid is high and ready is low. Of several pending pins, the lowest-numbered one is sent first, and a message already in the output register is not displaced.
- R10: With the output idle, a message is valid in the second cycle after the strobe that serviced it. A coalesced pulse lasts one cycle and follows the blocked update by one cycle.
- R11: After reset no message is valid, there is no coalesced pulse, all request and remote-IRR bits are clear, and every entry is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_id_i | input | 8 | Destination used for every pin 0 message |
| lvl_valid_i | input | 1 | Pin level update strobe |
| lvl_pin_i | input | clog2(NUM_PINS) | Pin number of the update |
| lvl_val_i | input | 1 | Raw input level of the update |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_pin_i | input | clog2(NUM_PINS) | Entry being written |
| cfg_vec_i | input | 8 | Vector field |
| cfg_dlv_i | input | 3 | Delivery mode field |
| cfg_dmode_i | input | 1 | Destination mode field, 1 = logical |
| cfg_pol_i | input | 1 | Polarity field, 1 = active low |
| cfg_trig_i | input | 1 | Trigger field, 1 = level |
| cfg_mask_i | input | 1 | Mask field, 1 = masked |
| cfg_dest_i | input | 8 | Destination field |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | Vector being acknowledged |
| eoi_level_i | input | 1 | 1 = level-type notice |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_pin_o | output | clog2(NUM_PINS) | Source pin of the message |
| msg_dest_o | output | 8 | Destination |
| msg_vec_o | output | 8 | Vector |
| msg_dmode_o | output | 1 | Destination mode |
| msg_trig_o | output | 1 | Trigger mode |
| msg_dlv_o | output | 3 | Delivery mode |
| msg_level_o | output | 1 | Asserted level, 1 with every message |
| coal_o | output | 1 | One-cycle coalesced pulse |
| coal_pin_o | output | clog2(NUM_PINS) | Pin of the coalesced update |

## Verification
The assertions watch the cycle-level invariants on every cycle. A remote IRR only exists on a level-mode entry and only rises while the entry is unmasked. An effective-low update always leaves the request bit clear. The arbiter grant is the lowest pending pin. A stalled message holds still with its level asserted, a pin 0 message is physical, and a coalesced pulse is single and follows an update. Only the bench scenarios show the sequence-dependent behaviour: an edge request blocked until the line drops, a level request reopened by a matching notice but not by an edge-type one, an entry rewrite that re-delivers at once, and the order of messages released after a long stall.

// File: rtl/pde_pkg.sv
package pde_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;   // 1 = level
    logic              pol;    // 1 = active low
    logic              dmode;  // 1 = logical
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vec;
  } redir_t;

  localparam redir_t REDIR_RESET = '{dest: '0, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                     dmode: 1'b0, dlv: '0, vec: '0};
endpackage

// File: rtl/pde_pin_slot.sv
module pde_pin_slot
  import pde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  redir_t           wr_ent_i,
  input  logic             ev_i,
  input  logic             ev_lvl_i,
  input  logic             eoi_v_i,
  input  logic             eoi_lvl_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             grant_i,
  output redir_t           ent_o,
  output logic             pend_o,
  output logic             coal_o
);
  redir_t ent_q, ent_n;
  logic   req_q, req_n, rirr_q, rirr_n, pend_q, pend_n, coal_n;

  // Ordered resolution: entry write, then level update, then end-of-interrupt.
  always_comb begin
    ent_n  = wr_i ? wr_ent_i : ent_q;
    req_n  = req_q;
    rirr_n = wr_i ? 1'b0 : rirr_q;
    pend_n = pend_q & ~grant_i;
    coal_n = 1'b0;
    if (wr_i && ent_n.trig && req_n && !ent_n.mask) begin
      pend_n = 1'b1;
      rirr_n = 1'b1;
    end
    if (ev_i) begin
      if (!(ev_lvl_i ^ ent_n.pol)) begin
        req_n = 1'b0;
      end else begin
        if (ent_n.trig ? !rirr_n : !req_n) begin
          if (!ent_n.mask) begin
            pend_n = 1'b1;
            rirr_n = rirr_n | ent_n.trig;
          end
        end else begin
          coal_n = 1'b1;
        end
        req_n = 1'b1;
      end
    end
    if (eoi_v_i && eoi_lvl_i && ent_n.trig && (ent_n.vec == eoi_vec_i)) begin
      rirr_n = 1'b0;
      if (!ent_n.mask && req_n) begin
        pend_n = 1'b1;
        rirr_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q  <= REDIR_RESET;
      req_q  <= 1'b0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ent_q  <= ent_n;
      req_q  <= req_n;
      rirr_q <= rirr_n;
      pend_q <= pend_n;
    end
  end

  assign ent_o  = ent_q;
  assign pend_o = pend_q;
  assign coal_o = coal_n;

  // R3: a remote IRR exists only on a level-mode entry
  p_rirr_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_q |-> ent_q.trig);
  // R4: a remote IRR rises only while the entry is unmasked
  p_rirr_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> !ent_q.mask);
  // R1: an effective-low update leaves the request bit clear
  p_low_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !wr_i && (ev_lvl_i == ent_q.pol)) |=> !req_q);
  // R9: only a pending pin is granted
  p_grant_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> pend_q);
endmodule

// File: rtl/pde_pick.sv
module pde_pick #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  assign gnt_o = req_i & (~req_i + N'(1));

  // R9: the grant is the single lowest-numbered request
  p_pick_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> ($onehot(gnt_o) && (((gnt_o - N'(1)) & req_i) == '0)));
  p_pick_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/pde_msg_out.sv
module pde_msg_out
  import pde_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_i,
  input  logic [PW-1:0]     pin_i,
  input  redir_t            ent_i,
  input  logic [DEST_W-1:0] boot_i,
  input  logic              ready_i,
  output logic              take_o,
  output logic              valid_o,
  output logic [PW-1:0]     pin_o,
  output logic [DEST_W-1:0] dest_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              dmode_o,
  output logic              trig_o,
  output logic [DLV_W-1:0]  dlv_o,
  output logic              level_o
);
  assign take_o = have_i && (!valid_o || ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      level_o <= 1'b0;
      pin_o   <= '0;
      dest_o  <= '0;
      vec_o   <= '0;
      dmode_o <= 1'b0;
      trig_o  <= 1'b0;
      dlv_o   <= '0;
    end else if (take_o) begin
      valid_o <= 1'b1;
      level_o <= 1'b1;
      pin_o   <= pin_i;
      vec_o   <= ent_i.vec;
      trig_o  <= ent_i.trig;
      dlv_o   <= ent_i.dlv;
      if (pin_i == '0) begin
        dest_o  <= boot_i;
        dmode_o <= 1'b0;
      end else begin
        dest_o  <= ent_i.dest;
        dmode_o <= ent_i.dmode;
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
      level_o <= 1'b0;
    end
  end

  // R9: a stalled message holds still
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(pin_o) && $stable(dest_o) && $stable(vec_o)
                               && $stable(dmode_o) && $stable(trig_o) && $stable(dlv_o)));
  // R8: every message asserts its level
  p_level_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> level_o);
  // R7: pin 0 always goes out in physical mode
  p_pin0_phys_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (pin_o == '0)) |-> !dmode_o);
endmodule

// File: rtl/pde_top.sv
module pde_top
  import pde_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEST_W-1:0] boot_id_i,
  input  logic              lvl_valid_i,
  input  logic [PW-1:0]     lvl_pin_i,
  input  logic              lvl_val_i,
  input  logic              cfg_we_i,
  input  logic [PW-1:0]     cfg_pin_i,
  input  logic [VEC_W-1:0]  cfg_vec_i,
  input  logic [DLV_W-1:0]  cfg_dlv_i,
  input  logic              cfg_dmode_i,
  input  logic              cfg_pol_i,
  input  logic              cfg_trig_i,
  input  logic              cfg_mask_i,
  input  logic [DEST_W-1:0] cfg_dest_i,
  input  logic              eoi_valid_i,
  input  logic [VEC_W-1:0]  eoi_vec_i,
  input  logic              eoi_level_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [PW-1:0]     msg_pin_o,
  output logic [DEST_W-1:0] msg_dest_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              msg_dmode_o,
  output logic              msg_trig_o,
  output logic [DLV_W-1:0]  msg_dlv_o,
  output logic              msg_level_o,
  output logic              coal_o,
  output logic [PW-1:0]     coal_pin_o
);
  redir_t              cfg_ent;
  redir_t              ent_a [NUM_PINS];
  logic [NUM_PINS-1:0] pend_v, coal_v, gnt_v;
  logic                take;
  logic [PW-1:0]       sel_pin, coal_idx;
  redir_t              sel_ent;

  assign cfg_ent = '{dest: cfg_dest_i, mask: cfg_mask_i, trig: cfg_trig_i, pol: cfg_pol_i,
                     dmode: cfg_dmode_i, dlv: cfg_dlv_i, vec: cfg_vec_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pde_pin_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cfg_we_i && (cfg_pin_i == PW'(g))),
      .wr_ent_i  (cfg_ent),
      .ev_i      (lvl_valid_i && (lvl_pin_i == PW'(g))),
      .ev_lvl_i  (lvl_val_i),
      .eoi_v_i   (eoi_valid_i),
      .eoi_lvl_i (eoi_level_i),
      .eoi_vec_i (eoi_vec_i),
      .grant_i   (gnt_v[g] && take),
      .ent_o     (ent_a[g]),
      .pend_o    (pend_v[g]),
      .coal_o    (coal_v[g])
    );
  end

  pde_pick #(.N(NUM_PINS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (pend_v),
    .gnt_o (gnt_v)
  );

  always_comb begin
    sel_pin  = '0;
    sel_ent  = REDIR_RESET;
    coal_idx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (gnt_v[i]) begin
        sel_pin = PW'(i);
        sel_ent = ent_a[i];
      end
      if (coal_v[i]) coal_idx = PW'(i);
    end
  end

  pde_msg_out #(.PW(PW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .have_i  (|pend_v),
    .pin_i   (sel_pin),
    .ent_i   (sel_ent),
    .boot_i  (boot_id_i),
    .ready_i (msg_ready_i),
    .take_o  (take),
    .valid_o (msg_valid_o),
    .pin_o   (msg_pin_o),
    .dest_o  (msg_dest_o),
    .vec_o   (msg_vec_o),
    .dmode_o (msg_dmode_o),
    .trig_o  (msg_trig_o),
    .dlv_o   (msg_dlv_o),
    .level_o (msg_level_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coal_o     <= 1'b0;
      coal_pin_o <= '0;
    end else begin
      coal_o     <= |coal_v;
      coal_pin_o <= coal_idx;
    end
  end

  // R2: at most one pin coalesces per cycle
  p_coal_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coal_v));
  // R10: a coalesced pulse follows an update by one cycle
  p_coal_after_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    coal_o |-> $past(lvl_valid_i));
endmodule

// File: tb/sim_pde_top.sv
module sim_pde_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int PW = 3;
  localparam logic [7:0] BOOT = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic lvl_valid_i = 0, lvl_val_i = 0, cfg_we_i = 0, cfg_dmode_i = 0, cfg_pol_i = 0;
  logic cfg_trig_i = 0, cfg_mask_i = 0, eoi_valid_i = 0, eoi_level_i = 0, msg_ready_i = 0;
  logic [PW-1:0] lvl_pin_i = '0, cfg_pin_i = '0;
  logic [7:0] cfg_vec_i = '0, cfg_dest_i = '0, eoi_vec_i = '0;
  logic [2:0] cfg_dlv_i = '0;
  logic msg_valid_o, msg_dmode_o, msg_trig_o, msg_level_o, coal_o;
  logic [PW-1:0] msg_pin_o, coal_pin_o;
  logic [7:0] msg_dest_o, msg_vec_o;
  logic [2:0] msg_dlv_o;

  pde_top #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_id_i(BOOT),
    .lvl_valid_i(lvl_valid_i), .lvl_pin_i(lvl_pin_i), .lvl_val_i(lvl_val_i),
    .cfg_we_i(cfg_we_i), .cfg_pin_i(cfg_pin_i), .cfg_vec_i(cfg_vec_i), .cfg_dlv_i(cfg_dlv_i),
    .cfg_dmode_i(cfg_dmode_i), .cfg_pol_i(cfg_pol_i), .cfg_trig_i(cfg_trig_i),
    .cfg_mask_i(cfg_mask_i), .cfg_dest_i(cfg_dest_i),
    .eoi_valid_i(eoi_valid_i), .eoi_vec_i(eoi_vec_i), .eoi_level_i(eoi_level_i),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_pin_o(msg_pin_o),
    .msg_dest_o(msg_dest_o), .msg_vec_o(msg_vec_o), .msg_dmode_o(msg_dmode_o),
    .msg_trig_o(msg_trig_o), .msg_dlv_o(msg_dlv_o), .msg_level_o(msg_level_o),
    .coal_o(coal_o), .coal_pin_o(coal_pin_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit [7:0] m_vec [N], m_dest [N];
  bit [2:0] m_dlv [N];
  bit m_dm [N], m_pol [N], m_trig [N], m_mask [N], m_req [N], m_rirr [N], m_pend [N];
  bit [31:0] got_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_svc(int i);
    if (!m_mask[i]) begin
      m_pend[i] = 1;
      if (m_trig[i]) m_rirr[i] = 1;
    end
  endfunction

  function automatic bit m_level(int p, bit v);
    bit c = 0;
    if (!(v ^ m_pol[p])) m_req[p] = 0;
    else begin
      if (m_trig[p] ? !m_rirr[p] : !m_req[p]) m_svc(p);
      else c = 1;
      m_req[p] = 1;
    end
    return c;
  endfunction

  function automatic bit [31:0] m_msg(int i);
    return {7'b0, 3'(i), (i == 0) ? BOOT : m_dest[i], m_vec[i],
            (i == 0) ? 1'b0 : m_dm[i], m_trig[i], m_dlv[i], 1'b1};
  endfunction

  function automatic bit [31:0] dut_msg();
    return {7'b0, msg_pin_o, msg_dest_o, msg_vec_o, msg_dmode_o, msg_trig_o, msg_dlv_o, msg_level_o};
  endfunction

  // Collect messages under random back-pressure and compare with the model.
  task automatic drain(input string tag);
    bit any = 0, stalled = 0;
    bit [31:0] held = '0;
    for (int i = 0; i < N; i++) any |= m_pend[i];
    got_q.delete();
    for (int c = 0; c < 56; c++) begin
      bit r = (c >= 40) ? 1'b1 : ($urandom % 4 != 0);
      if (c == 1) chk(msg_valid_o == any, {tag, " R10 message latency"}, msg_valid_o, any);
      if (stalled) chk(dut_msg() == held, {tag, " R9 stalled message stable"}, dut_msg(), held);
      stalled = msg_valid_o && !r;
      held = dut_msg();
      msg_ready_i = r;
      if (msg_valid_o && r) got_q.push_back(dut_msg());
      @(negedge clk);
    end
    msg_ready_i = 0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i]) begin
        if (got_q.size() == 0) chk(0, {tag, " R8 missing message"}, 0, m_msg(i));
        else begin
          bit [31:0] g = got_q.pop_front();
          chk(g == m_msg(i), {tag, " R8 R9 message content and order"}, g, m_msg(i));
        end
        m_pend[i] = 0;
      end
    end
    chk(got_q.size() == 0, {tag, " R4 no extra message"}, got_q.size(), 0);
  endtask

  task automatic fire_raw(input int p, input bit v, input string tag);
    bit ec = m_level(p, v);
    lvl_valid_i = 1; lvl_pin_i = PW'(p); lvl_val_i = v;
    @(negedge clk);
    lvl_valid_i = 0;
    chk(coal_o == ec, {tag, " R2 R3 coalesced pulse"}, coal_o, ec);
    if (ec) chk(coal_pin_o == PW'(p), {tag, " R2 coalesced pin"}, coal_pin_o, p);
  endtask

  task automatic fire(input int p, input bit v, input string tag);
    fire_raw(p, v, tag);
    drain(tag);
  endtask

  task automatic cfg(input int p, input bit [7:0] vec, input bit [2:0] dlv, input bit dm,
                     input bit pol, input bit trig, input bit mask, input bit [7:0] dest,
                     input string tag);
    m_vec[p] = vec; m_dlv[p] = dlv; m_dm[p] = dm; m_pol[p] = pol;
    m_trig[p] = trig; m_mask[p] = mask; m_dest[p] = dest;
    m_rirr[p] = 0;
    if (trig && m_req[p]) m_svc(p);
    cfg_we_i = 1; cfg_pin_i = PW'(p); cfg_vec_i = vec; cfg_dlv_i = dlv; cfg_dmode_i = dm;
    cfg_pol_i = pol; cfg_trig_i = trig; cfg_mask_i = mask; cfg_dest_i = dest;
    @(negedge clk);
    cfg_we_i = 0;
    chk(coal_o == 0, {tag, " R6 write never coalesces"}, coal_o, 0);
    drain(tag);
  endtask

  task automatic eoi(input bit [7:0] vec, input bit lvl, input string tag);
    for (int i = 0; i < N; i++)
      if (lvl && m_trig[i] && m_vec[i] == vec) begin
        m_rirr[i] = 0;
        if (!m_mask[i] && m_req[i]) m_svc(i);
      end
    eoi_valid_i = 1; eoi_vec_i = vec; eoi_level_i = lvl;
    @(negedge clk);
    eoi_valid_i = 0;
    drain(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 run hung actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_mask[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(msg_valid_o == 0, "R11 no message after reset", msg_valid_o, 0);
    chk(coal_o == 0, "R11 no coalesced pulse after reset", coal_o, 0);
    fire(3, 1, "R11 entries masked after reset");
    fire(3, 0, "R1 low clears request");

    // Edge mode
    cfg(2, 8'h31, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12, "R8 edge entry write");
    fire(2, 1, "R2 edge first rise");
    fire(2, 1, "R2 edge repeat coalesced");
    fire(2, 0, "R1 edge drop");
    fire(2, 1, "R2 edge second rise");
    // Polarity
    cfg(4, 8'h44, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03, "R1 active-low entry");
    fire(4, 0, "R1 active-low asserted");
    fire(4, 1, "R1 active-low released");
    // Level mode and end of interrupt
    cfg(5, 8'h41, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, "R3 level entry write");
    fire(5, 1, "R3 level first delivery");
    fire(5, 1, "R3 level blocked by remote IRR");
    eoi(8'h41, 1'b0, "R5 edge-type notice ignored");
    fire(5, 1, "R5 still blocked after edge notice");
    eoi(8'h40, 1'b1, "R5 non-matching vector ignored");
    eoi(8'h41, 1'b1, "R5 notice re-delivers asserted pin");
    cfg(5, 8'h41, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h78, "R6 rewrite re-delivers asserted level pin");
    fire(5, 0, "R1 level drop");
    eoi(8'h41, 1'b1, "R5 notice with request clear");
    fire(5, 1, "R3 level after notice");
    // Masked level pin, then unmask by write
    cfg(6, 8'h50, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 8'h09, "R4 masked level entry");
    fire(6, 1, "R4 masked level no message");
    fire(6, 1, "R4 masked level never coalesces");
    cfg(6, 8'h50, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h09, "R6 unmask services pending level");
    // Pin 0 override
    cfg(0, 8'h30, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33, "R7 pin 0 entry");
    fire(0, 1, "R7 pin 0 physical to boot ID");
    // One notice, two matching pins
    cfg(7, 8'h41, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h21, "R5 second entry on same vector");
    fire(7, 1, "R3 second level pin");
    eoi(8'h41, 1'b1, "R5 R9 notice re-delivers both pins in order");

    // Stall ordering
    cfg(1, 8'h61, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, "R9 edge entry 1");
    cfg(3, 8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, "R9 edge entry 3");
    cfg(6, 8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, "R9 edge entry 6");
    fire(1, 0, "R9 clear 1"); fire(3, 0, "R9 clear 3"); fire(6, 0, "R9 clear 6");
    msg_ready_i = 0;
    fire_raw(6, 1, "R9 stalled 6");
    fire_raw(3, 1, "R9 stalled 3");
    fire_raw(1, 1, "R9 stalled 1");
    repeat (3) @(negedge clk);
    chk(msg_valid_o && msg_pin_o == 3'd6, "R9 first loaded message held", msg_pin_o, 6);
    got_q.delete();
    msg_ready_i = 1;
    for (int c = 0; c < 6; c++) begin
      if (msg_valid_o) got_q.push_back(32'(msg_pin_o));
      @(negedge clk);
    end
    msg_ready_i = 0;
    chk(got_q.size() == 3, "R9 stalled message count", got_q.size(), 3);
    if (got_q.size() == 3) begin
      chk(got_q[0] == 6, "R9 order slot 0", got_q[0], 6);
      chk(got_q[1] == 1, "R9 order slot 1 lowest pending", got_q[1], 1);
      chk(got_q[2] == 3, "R9 order slot 2", got_q[2], 3);
    end
    for (int i = 0; i < N; i++) m_pend[i] = 0;

    // Random mix
    for (int k = 0; k < 250; k++) begin
      int sel = $urandom % 10;
      int p = $urandom % N;
      if (sel < 2)
        cfg(p, 8'h20 + 8'($urandom % 3), 3'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 4 == 0), 8'($urandom), "R6 random write");
      else if (sel < 8)
        fire(p, 1'($urandom), "R1 R2 R3 random update");
      else
        eoi(8'h20 + 8'($urandom % 3), ($urandom % 4 != 0), "R5 random notice");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule